// File: doc/BRIEF.md
# Low-Speed USB Packet Transmitter

This block turns a short byte sequence into a low-speed USB packet on the D+/D- pair. A request starts a packet. The block first sends the synchronization byte. It then fetches each further byte through a combinational read port and sends it least significant bit first. A zero is inserted after every run of six ones, and the whole stream is NRZI encoded. The packet closes with an end-of-packet pattern, and then the line drivers are released. A separate handshake request sends the synchronization byte followed by a single PID byte, without reading the byte source.

The block also holds the active device address. A pending address is committed only when a data packet finishes, so that a handshake never moves the device to its new address early. A one-cycle done strobe marks the cycle in which the drivers have just been released.

Top module: `usb_ls_tx`

## Requirements
- R1: Every line symbol is held for exactly CLKS_PER_BIT clocks (11 by default). The drivers stay enabled for CLKS_PER_BIT × (transmitted bits + 3) clocks.
- R2: In the cycle after a request is accepted, the pins show J (dp_o=0, dm_o=1) with oe_o=0. In the next cycle oe_o is 1 and the synchronization byte 0x80 starts, sent LSB first, which gives the symbols K J K J K J K K.
- R3: Data bytes are read from rd_data_i while rd_addr_o holds the byte index, where 0 is the first byte after sync. Each byte goes out LSB first. A 0 bit toggles the line and a 1 bit holds it. J is dp_o=0/dm_o=1 and K is dp_o=1/dm_o=0.
- R4: After six consecutive 1 bits, a 0 bit is inserted. The run is counted across byte boundaries, and a stuffed bit is also inserted after the final bit of the packet. The run count is cleared by every 0, including inserted ones, and starts at zero at the start of sync.
- R5: byte_cnt_i is the total byte count including sync (2 to 12). A value below 2 acts as 2 and a value above 12 acts as 12.
- R6: End of packet is SE0 (dp_o=dm_o=0) for two bit times, then J for one bit time. After that, oe_o=0 with dp_o=dm_o=0, so no pull-up is driven.
- R7: done_o is high for exactly one cycle: the first cycle with oe_o low after the end-of-packet J.
- R8: hs_req_i sends sync followed by hs_pid_i, two bytes in total. The byte source is not used.
- R9: dev_addr_o takes new_addr_i when a data packet ends, and the new value is visible together with done_o. It does not change after a handshake.
- R10: start_i and hs_req_i are ignored from acceptance of a request until the done_o cycle. If both are high in idle, the handshake is taken.
- R11: After reset, oe_o=0, dp_o=dm_o=0, done_o=0 and dev_addr_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, CLKS_PER_BIT cycles per bit |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a data packet |
| byte_cnt_i | input | CNT_W (4) | Total bytes including sync |
| rd_addr_o | output | AW (4) | Index of the data byte being fetched |
| rd_data_i | input | 8 | Byte at rd_addr_o, read combinationally |
| hs_req_i | input | 1 | Start a handshake packet |
| hs_pid_i | input | 8 | PID byte for the handshake |
| new_addr_i | input | ADDR_W (7) | Pending device address |
| dev_addr_o | output | ADDR_W (7) | Active device address |
| dp_o | output | 1 | D+ level |
| dm_o | output | 1 | D- level |
| oe_o | output | 1 | Driver enable for D+/D- |
| done_o | output | 1 | One-cycle end-of-transmission strobe |

## Verification
The bench uses the default build: CLKS_PER_BIT=11, MAX_BYTES=12 and ADDR_W=7. With 11 clocks per bit, a mid-cell sample lands five clocks from either edge, so an error of one clock in any cell boundary shows up as a wrong symbol or as a wrong enable length. MAX_BYTES=12 puts both clamp limits and the full-length packet within reach. It also allows runs of all-ones bytes whose stuffing crosses the sync boundary, the byte boundaries and the final bit.

// File: rtl/usb_ls_tx_pkg.sv
package usb_ls_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREP,
    ST_DATA,
    ST_SE0,
    ST_EOPJ,
    ST_DONE
  } tx_state_e;

  localparam logic [7:0] SYNC_BYTE = 8'h80;
  localparam int unsigned RUN_LEN  = 6;
endpackage

// File: rtl/usb_ls_bit_timer.sv
module usb_ls_bit_timer #(
  parameter int unsigned TW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [TW-1:0] limit_i,
  output logic          tick_o
);
  logic [TW-1:0] cnt_q;

  assign tick_o = (cnt_q == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  // R1
  tmr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |-> cnt_q <= limit_i);
endmodule

// File: rtl/usb_ls_serializer.sv
module usb_ls_serializer
  import usb_ls_tx_pkg::*;
#(
  parameter int unsigned MAX_BYTES = 12,
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned AW        = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic             hs_i,
  input  logic [CNT_W-1:0] byte_cnt_i,
  input  logic [7:0]       pid_i,
  input  logic [7:0]       rd_data_i,
  input  logic             emit_i,
  output logic [AW-1:0]    rd_addr_o,
  output logic             line_k_o,
  output logic             more_o
);
  localparam logic [CNT_W-1:0] MIN_CNT = CNT_W'(2);
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_BYTES);
  localparam logic [2:0]       RUN_MAX = 3'(RUN_LEN);

  logic [7:0]       sh_q;
  logic [3:0]       left_q;
  logic [CNT_W-1:0] bytes_q;
  logic [2:0]       ones_q;
  logic             line_q;
  logic             hs_q;
  logic [7:0]       pid_q;
  logic [AW-1:0]    addr_q;
  logic [CNT_W-1:0] cnt_eff;
  logic             stuff;
  logic             cur_bit;
  logic [7:0]       next_byte;

  always_comb begin
    if (byte_cnt_i < MIN_CNT)      cnt_eff = MIN_CNT;
    else if (byte_cnt_i > MAX_CNT) cnt_eff = MAX_CNT;
    else                           cnt_eff = byte_cnt_i;
  end

  assign stuff     = (ones_q == RUN_MAX);
  assign cur_bit   = stuff ? 1'b0 : sh_q[0];
  assign next_byte = hs_q ? pid_q : rd_data_i;
  assign more_o    = (left_q != 4'd0) || stuff;
  assign line_k_o  = line_q;
  assign rd_addr_o = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      left_q  <= '0;
      bytes_q <= '0;
      ones_q  <= '0;
      line_q  <= 1'b0;
      hs_q    <= 1'b0;
      pid_q   <= '0;
      addr_q  <= '0;
    end else if (init_i) begin
      sh_q    <= SYNC_BYTE;
      left_q  <= 4'd8;
      bytes_q <= hs_i ? CNT_W'(1) : cnt_eff - 1'b1;
      ones_q  <= '0;
      line_q  <= 1'b0;
      hs_q    <= hs_i;
      pid_q   <= pid_i;
      addr_q  <= '0;
    end else if (emit_i) begin
      line_q <= line_q ^ ~cur_bit;
      if (stuff) begin
        ones_q <= '0;
      end else begin
        ones_q <= sh_q[0] ? ones_q + 1'b1 : 3'd0;
        if (left_q == 4'd1 && bytes_q != '0) begin
          sh_q    <= next_byte;
          left_q  <= 4'd8;
          bytes_q <= bytes_q - 1'b1;
          addr_q  <= addr_q + 1'b1;
        end else begin
          sh_q   <= sh_q >> 1;
          left_q <= left_q - 1'b1;
        end
      end
    end
  end

  // R4
  stuff_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (emit_i && !init_i && ones_q == RUN_MAX) |=> line_k_o != $past(line_k_o));
  // R4
  run_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ones_q <= RUN_MAX);
  // R5
  addr_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(addr_q) < MAX_BYTES);
endmodule

// File: rtl/usb_ls_tx.sv
module usb_ls_tx
  import usb_ls_tx_pkg::*;
#(
  parameter int unsigned CLKS_PER_BIT = 11,
  parameter int unsigned MAX_BYTES    = 12,
  parameter int unsigned ADDR_W       = 7,
  parameter int unsigned CNT_W        = $clog2(MAX_BYTES + 1),
  parameter int unsigned AW           = $clog2(MAX_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  byte_cnt_i,
  output logic [AW-1:0]     rd_addr_o,
  input  logic [7:0]        rd_data_i,
  input  logic              hs_req_i,
  input  logic [7:0]        hs_pid_i,
  input  logic [ADDR_W-1:0] new_addr_i,
  output logic [ADDR_W-1:0] dev_addr_o,
  output logic              dp_o,
  output logic              dm_o,
  output logic              oe_o,
  output logic              done_o
);
  localparam int unsigned TW = $clog2(2 * CLKS_PER_BIT);
  localparam logic [TW-1:0] BIT_LIM = TW'(CLKS_PER_BIT - 1);
  localparam logic [TW-1:0] SE0_LIM = TW'(2 * CLKS_PER_BIT - 1);

  tx_state_e         state_q, state_d;
  logic              hs_q;
  logic [ADDR_W-1:0] addr_q;
  logic              tick, tmr_clr, emit, init, more, line_k;
  logic [TW-1:0]     limit;

  assign init    = (state_q == ST_IDLE) && (start_i || hs_req_i);
  assign emit    = (state_q == ST_PREP) || (state_q == ST_DATA && tick && more);
  assign limit   = (state_q == ST_SE0) ? SE0_LIM : BIT_LIM;
  assign tmr_clr = (state_d != state_q);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (init) state_d = ST_PREP;
      ST_PREP: state_d = ST_DATA;
      ST_DATA: if (tick && !more) state_d = ST_SE0;
      ST_SE0:  if (tick) state_d = ST_EOPJ;
      ST_EOPJ: if (tick) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      hs_q    <= 1'b0;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      if (init) hs_q <= hs_req_i;
      if (state_q == ST_EOPJ && tick && !hs_q) addr_q <= new_addr_i;
    end
  end

  usb_ls_bit_timer #(.TW(TW)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (tmr_clr),
    .limit_i (limit),
    .tick_o  (tick)
  );

  usb_ls_serializer #(
    .MAX_BYTES (MAX_BYTES),
    .CNT_W     (CNT_W),
    .AW        (AW)
  ) u_ser (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .init_i     (init),
    .hs_i       (hs_req_i),
    .byte_cnt_i (byte_cnt_i),
    .pid_i      (hs_pid_i),
    .rd_data_i  (rd_data_i),
    .emit_i     (emit),
    .rd_addr_o  (rd_addr_o),
    .line_k_o   (line_k),
    .more_o     (more)
  );

  always_comb begin
    dp_o   = 1'b0;
    dm_o   = 1'b0;
    oe_o   = 1'b0;
    done_o = 1'b0;
    unique case (state_q)
      ST_PREP: dm_o = 1'b1;
      ST_DATA: begin dp_o = line_k; dm_o = ~line_k; oe_o = 1'b1; end
      ST_SE0:  oe_o = 1'b1;
      ST_EOPJ: begin dm_o = 1'b1; oe_o = 1'b1; end
      ST_DONE: done_o = 1'b1;
      default: ;
    endcase
  end

  assign dev_addr_o = addr_q;

  // R2
  j_before_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_o) |-> ($past(dm_o) && !$past(dp_o)));
  // R6
  eop_ends_j_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oe_o) |-> ($past(dm_o) && !$past(dp_o) && !dp_o && !dm_o));
  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R7
  done_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!oe_o && $past(oe_o)));
  // R9
  addr_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dev_addr_o) |-> (done_o && !hs_q));
  // R10
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA) |=> (state_q == ST_DATA || state_q == ST_SE0));
endmodule

// File: tb/tb_usb_ls_tx.sv
`timescale 1ns/1ps
module tb_usb_ls_tx;
  localparam int CPB = 11;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [3:0] byte_cnt_i = '0;
  logic [3:0] rd_addr_o;
  logic [7:0] rd_data_i;
  logic       hs_req_i = 1'b0;
  logic [7:0] hs_pid_i = '0;
  logic [6:0] new_addr_i = '0;
  logic [6:0] dev_addr_o;
  logic       dp_o, dm_o, oe_o, done_o;
  logic [7:0] mem [0:15];

  int errors = 0;
  int checks = 0;
  logic [1:0] exp_q[$];
  string      tag_q[$];
  int         exp_cells = 0;
  string      len_tag = "R1";

  assign rd_data_i = mem[rd_addr_o];

  always #2.5 clk_i = ~clk_i;

  usb_ls_tx dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .byte_cnt_i(byte_cnt_i),
    .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i), .hs_req_i(hs_req_i),
    .hs_pid_i(hs_pid_i), .new_addr_i(new_addr_i), .dev_addr_o(dev_addr_o),
    .dp_o(dp_o), .dm_o(dm_o), .oe_o(oe_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void push_cell(input logic [1:0] sym, input string tag);
    exp_q.push_back(sym);
    tag_q.push_back(tag);
  endfunction

  // builds expected symbols: J=01, K=10, SE0=00 as {dp,dm}
  function automatic void build(input bit hs, input logic [7:0] pid, input int n, input string dtag);
    logic [7:0] b;
    bit lvl_k = 1'b0;
    int ones = 0;
    for (int i = 0; i < n; i++) begin
      b = (i == 0) ? 8'h80 : (hs ? pid : mem[i-1]);
      for (int k = 0; k < 8; k++) begin
        if (!b[k]) lvl_k = !lvl_k;
        push_cell(lvl_k ? 2'b10 : 2'b01, (i == 0) ? "R2" : dtag);
        ones = b[k] ? ones + 1 : 0;
        if (ones == 6) begin
          lvl_k = !lvl_k;
          push_cell(lvl_k ? 2'b10 : 2'b01, "R4");
          ones = 0;
        end
      end
    end
    push_cell(2'b00, "R6");
    push_cell(2'b00, "R6");
    push_cell(2'b01, "R6");
    exp_cells = exp_q.size();
  endfunction

  task automatic wait_done();
    do @(negedge clk_i); while (!done_o);
  endtask

  task automatic send(input bit hs, input logic [7:0] pid, input logic [3:0] cnt_in,
                      input int n_eff, input string dtag, input string ltag, input bit poke);
    build(hs, pid, n_eff, dtag);
    len_tag = ltag;
    @(negedge clk_i);
    byte_cnt_i = cnt_in;
    hs_pid_i = pid;
    if (hs) hs_req_i = 1'b1; else start_i = 1'b1;
    @(negedge clk_i);
    hs_req_i = 1'b0;
    start_i = 1'b0;
    chk(!oe_o && !dp_o && dm_o, "R2", {oe_o, dp_o, dm_o}, 3'b001);
    if (poke) begin
      repeat (150) @(negedge clk_i);
      byte_cnt_i = 4'd9;
      start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
      hs_req_i = 1'b1;
      @(negedge clk_i);
      hs_req_i = 1'b0;
    end
    wait_done();
    if (poke) begin
      for (int i = 0; i < 30; i++) begin
        @(negedge clk_i);
        chk(!oe_o && !dm_o, "R10", {oe_o, dm_o}, 0);
      end
    end
  endtask

  // monitor: samples mid-cell and pops expected symbols
  initial begin
    bit was_oe = 1'b0;
    bit after_done = 1'b0;
    int cnt = 0;
    logic [1:0] e;
    string t;
    forever begin
      @(negedge clk_i);
      if (after_done) begin
        chk(!done_o, "R7", done_o, 0);
        after_done = 1'b0;
      end
      if (oe_o) begin
        if (!was_oe) cnt = 0;
        if (cnt % CPB == 5) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R1", {dp_o, dm_o}, 0);
          end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk({dp_o, dm_o} == e, t, {dp_o, dm_o}, e);
          end
        end
        cnt++;
      end else if (was_oe) begin
        chk(cnt == exp_cells * CPB, len_tag, cnt, exp_cells * CPB);
        chk(done_o, "R7", done_o, 1);
        chk(!dp_o && !dm_o, "R6", {dp_o, dm_o}, 0);
        chk(exp_q.size() == 0, len_tag, exp_q.size(), 0);
        exp_q.delete();
        tag_q.delete();
        after_done = 1'b1;
      end
      was_oe = oe_o;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 8'(i * 37 + 11);
    repeat (3) @(negedge clk_i);
    // R11
    chk(!oe_o && !dp_o && !dm_o && !done_o, "R11", {oe_o, dp_o, dm_o, done_o}, 0);
    chk(dev_addr_o == 7'd0, "R11", dev_addr_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // R3 R9: short data packet
    mem[0] = 8'hC3; mem[1] = 8'h5A;
    new_addr_i = 7'h2A;
    send(1'b0, 8'h00, 4'd3, 3, "R3", "R1", 1'b0);
    chk(dev_addr_o == 7'h2A, "R9", dev_addr_o, 7'h2A);

    // R8 R9: ACK handshake leaves address
    new_addr_i = 7'h15;
    send(1'b1, 8'hD2, 4'd7, 2, "R8", "R8", 1'b0);
    chk(dev_addr_o == 7'h2A, "R9", dev_addr_o, 7'h2A);

    // R4: all-ones bytes, stuffing across boundaries and after last bit
    mem[0] = 8'hFF; mem[1] = 8'hFF; mem[2] = 8'hFF;
    new_addr_i = 7'h01;
    send(1'b0, 8'h00, 4'd4, 4, "R4", "R4", 1'b0);
    chk(dev_addr_o == 7'h01, "R9", dev_addr_o, 7'h01);

    // R5: full length and minimum length
    for (int i = 0; i < 11; i++) mem[i] = 8'(i * 53 + 7);
    mem[4] = 8'h7E; mem[5] = 8'hFC;
    new_addr_i = 7'h7F;
    send(1'b0, 8'h00, 4'd12, 12, "R3", "R5", 1'b0);
    chk(dev_addr_o == 7'h7F, "R9", dev_addr_o, 7'h7F);
    mem[0] = 8'h3F;
    send(1'b0, 8'h00, 4'd2, 2, "R3", "R5", 1'b0);

    // R5: clamping
    mem[0] = 8'hA5;
    send(1'b0, 8'h00, 4'd0, 2, "R5", "R5", 1'b0);
    send(1'b0, 8'h00, 4'd15, 12, "R5", "R5", 1'b0);

    // R10: requests during a packet are ignored
    send(1'b0, 8'h00, 4'd5, 5, "R10", "R10", 1'b1);

    // R8: NAK handshake
    new_addr_i = 7'h33;
    send(1'b1, 8'h5A, 4'd12, 2, "R8", "R8", 1'b0);
    chk(dev_addr_o == 7'h7F, "R9", dev_addr_o, 7'h7F);

    repeat (5) @(negedge clk_i);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule